// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block is the last stage in front of six PWM pins. Three generator signals come in, one per channel pair. The stage turns them into six pin values and six output enables.

A two-bit mode selects how each pair is formed:
- **Independent:** both pins of a pair carry their own generator signal.
- **Synchronized:** every pin follows generator 0.
- **Complementary:** the even pin carries the generator and the odd pin carries its inverse.

In complementary mode, each pair can have a programmable dead time. During the dead time both pins of the pair stay low, so a half-bridge never conducts on both sides at once.

After the pair logic, each channel passes through three overrides in a fixed order:
1. A per-channel mask, which replaces the signal with a fixed bit.
2. A brake override, which forces a per-channel safe level while the brake input is high.
3. A per-channel polarity inversion.

The even pins and the odd pins each have one output enable per group. A disabled group is meant to be tri-stated by the pad. All pin values and enables leave the block from registers, so every pin is free of glitches.

There is no data stream here; every input is a plain control level sampled on each clock.

Top module: `pwm_out_stage`

## Requirements
- R1: Channel 2p+1 is the odd pin of pair p and channel 2p is its even pin. Mode encoding: 0 (independent) drives channels 2p and 2p+1 with gen_i[p]. 2 (synchronized) drives all channels with gen_i[0]. 3 is reserved and behaves as mode 0.
- R2: In mode 1 (complementary) with dt_en_i[p]=0, channel 2p carries gen_i[p] and channel 2p+1 carries its inverse, with no extra delay.
- R3: In mode 1 with dt_en_i[p]=1, both pins of pair p are low for dt_len_i cycles after a change of gen_i[p]. After that, the pin that became active rises. The pin that became inactive falls at once. A further change inside the window restarts it.
- R4: dt_en_i has no effect in modes 0, 2 and 3.
- R5: dt_len_i covers the full 11-bit range; a length of 2047 delays the rising pin by exactly 2047 cycles.
- R6: When mask_en_i[c]=1, channel c takes mask_val_i[c] in place of the dead-timed signal, including inside a dead-time window.
- R7: While brake_i=1, every channel c takes brake_lvl_i[c], with priority over the mask.
- R8: When neg_pol_i[c]=1, the final value of channel c is inverted; the inversion applies after mask and brake.
- R9: pin_oe_o[c] equals even_oe_i for even c and odd_oe_i for odd c.
- R10: Every input change reaches pin_o and pin_oe_o at the first rising clock edge after it is applied. While rst_n=0, pin_o and pin_oe_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_i | input | 3 | Generator signal per pair |
| mode_i | input | 2 | Pair mode: 0 independent, 1 complementary, 2 synchronized, 3 reserved |
| dt_len_i | input | 11 | Dead-time length in clock cycles |
| dt_en_i | input | 3 | Dead-time enable per pair |
| mask_en_i | input | 6 | Mask enable per channel |
| mask_val_i | input | 6 | Mask value per channel |
| brake_i | input | 1 | Brake active |
| brake_lvl_i | input | 6 | Level forced per channel while braking, before polarity |
| neg_pol_i | input | 6 | Active-low select per channel |
| even_oe_i | input | 1 | Output enable for channels 0, 2, 4 |
| odd_oe_i | input | 1 | Output enable for channels 1, 3, 5 |
| pin_o | output | 6 | Registered pin values |
| pin_oe_o | output | 6 | Registered pin output enables |

## Verification
Every result except a dead-timed rise is due on the first rising edge after the stimulus. The bench therefore drives on the falling edge and samples 1 ns after the next rising edge. A dead-timed rise appears dt_len_i edges later than an undelayed one. The bench samples on every edge from the change through dt_len_i+1 and expects the pin low exactly while the edge index is below dt_len_i. The override and mode sweeps hold the generator steady long enough that no dead-time window is open while they are sampled.

// File: rtl/pwm_out_pkg.sv
`timescale 1ns/1ps
package pwm_out_pkg;
  typedef enum logic [1:0] {
    MODE_INDEP = 2'd0,
    MODE_COMP  = 2'd1,
    MODE_SYNC  = 2'd2,
    MODE_RSVD  = 2'd3
  } pwm_mode_e;
endpackage

// File: rtl/pwm_dt_pair.sv
`timescale 1ns/1ps
// Forms one even/odd pair from a generator signal; inserts dead time in complementary mode.
module pwm_dt_pair #(
  parameter int DT_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_i,
  input  logic            comp_mode_i,
  input  logic            dt_en_i,
  input  logic [DT_W-1:0] dt_len_i,
  output logic            prim_o,
  output logic            comp_o
);
  logic            gen_q;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            chg, dt_act, quiet;

  assign dt_act = comp_mode_i & dt_en_i;
  assign chg    = gen_i ^ gen_q;

  always_comb begin
    if (!dt_act)             cnt_d = '0;
    else if (chg)            cnt_d = dt_len_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  assign quiet  = (cnt_d == '0);
  assign prim_o = gen_i & quiet;
  assign comp_o = comp_mode_i ? (~gen_i & quiet) : gen_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      gen_q <= gen_i;
      cnt_q <= cnt_d;
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_mode_i |-> !(prim_o && comp_o));
  // R3
  dt_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_act && !chg && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  dt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dt_act |=> (cnt_q == '0));
  // R2
  exact_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_mode_i && !dt_en_i) |-> (comp_o == !prim_o));
endmodule

// File: rtl/pwm_chan_ovr.sv
`timescale 1ns/1ps
// Per-channel override chain: mask, then brake, then polarity.
module pwm_chan_ovr (
  input  logic raw_i,
  input  logic mask_en_i,
  input  logic mask_val_i,
  input  logic brake_i,
  input  logic brake_lvl_i,
  input  logic neg_pol_i,
  output logic val_o
);
  logic masked, braked;
  assign masked = mask_en_i ? mask_val_i : raw_i;
  assign braked = brake_i ? brake_lvl_i : masked;
  assign val_o  = braked ^ neg_pol_i;

  // R7
  always_comb begin
    brake_wins_chk: assert (!brake_i || (braked == brake_lvl_i));
  end
endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage
  import pwm_out_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int DT_W      = 11,
  localparam int NCH      = 2 * NUM_PAIRS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] gen_i,
  input  logic [1:0]           mode_i,
  input  logic [DT_W-1:0]      dt_len_i,
  input  logic [NUM_PAIRS-1:0] dt_en_i,
  input  logic [NCH-1:0]       mask_en_i,
  input  logic [NCH-1:0]       mask_val_i,
  input  logic                 brake_i,
  input  logic [NCH-1:0]       brake_lvl_i,
  input  logic [NCH-1:0]       neg_pol_i,
  input  logic                 even_oe_i,
  input  logic                 odd_oe_i,
  output logic [NCH-1:0]       pin_o,
  output logic [NCH-1:0]       pin_oe_o
);
  pwm_mode_e      mode;
  logic           comp_mode;
  logic [NCH-1:0] raw, fin;

  assign mode      = pwm_mode_e'(mode_i);
  assign comp_mode = (mode == MODE_COMP);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic src;
    assign src = (mode == MODE_SYNC) ? gen_i[0] : gen_i[p];
    pwm_dt_pair #(.DT_W(DT_W)) pair_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .gen_i       (src),
      .comp_mode_i (comp_mode),
      .dt_en_i     (dt_en_i[p]),
      .dt_len_i    (dt_len_i),
      .prim_o      (raw[2*p]),
      .comp_o      (raw[2*p+1])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam bit IS_ODD = (c % 2) == 1;
    logic oe_sel;
    assign oe_sel = IS_ODD ? odd_oe_i : even_oe_i;

    pwm_chan_ovr ovr_i (
      .raw_i       (raw[c]),
      .mask_en_i   (mask_en_i[c]),
      .mask_val_i  (mask_val_i[c]),
      .brake_i     (brake_i),
      .brake_lvl_i (brake_lvl_i[c]),
      .neg_pol_i   (neg_pol_i[c]),
      .val_o       (fin[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_o[c]    <= 1'b0;
        pin_oe_o[c] <= 1'b0;
      end else begin
        pin_o[c]    <= fin[c];
        pin_oe_o[c] <= oe_sel;
      end
    end

    // R9
    oe_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pin_oe_o[c] == $past(IS_ODD ? odd_oe_i : even_oe_i)));
  end
endmodule

// File: tb/pwm_out_stage_tb_top.sv
`timescale 1ns/1ps
module pwm_out_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  gen_i = '0;
  logic [1:0]  mode_i = '0;
  logic [10:0] dt_len_i = '0;
  logic [2:0]  dt_en_i = '0;
  logic [5:0]  mask_en_i = '0, mask_val_i = '0, brake_lvl_i = '0, neg_pol_i = '0;
  logic        brake_i = 1'b0, even_oe_i = 1'b0, odd_oe_i = 1'b0;
  logic [5:0]  pin_o, pin_oe_o;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_out_stage dut_i (
    .clk(clk), .rst_n(rst_n), .gen_i(gen_i), .mode_i(mode_i),
    .dt_len_i(dt_len_i), .dt_en_i(dt_en_i), .mask_en_i(mask_en_i),
    .mask_val_i(mask_val_i), .brake_i(brake_i), .brake_lvl_i(brake_lvl_i),
    .neg_pol_i(neg_pol_i), .even_oe_i(even_oe_i), .odd_oe_i(odd_oe_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Expected pins with no open dead-time window (R1, R2, R6, R7, R8).
  function automatic logic [5:0] model(input logic [2:0] g, input logic [1:0] m,
      input logic [5:0] me, input logic [5:0] mv, input logic br,
      input logic [5:0] bl, input logic [5:0] np);
    logic [5:0] r;
    for (int c = 0; c < 6; c++) begin
      logic s, v;
      s = (m == 2'd2) ? g[0] : g[c/2];
      v = (m == 2'd1 && (c % 2) == 1) ? ~s : s;
      if (me[c]) v = mv[c];
      if (br) v = bl[c];
      r[c] = v ^ np[c];
    end
    return r;
  endfunction

  task automatic step(); @(posedge clk); #1; endtask
  task automatic settle(input int n); for (int i = 0; i < n; i++) step(); @(negedge clk); endtask

  // One dead-time run on pair 0 (enabled) and pair 1 (disabled), length d.
  task automatic dt_run(input int d);
    mode_i = 2'd1; dt_en_i = 3'b001; dt_len_i = 11'(d); gen_i = 3'b000;
    mask_en_i = '0; brake_i = 1'b0; neg_pol_i = '0;
    settle(d + 3);
    gen_i = 3'b011;
    for (int j = 0; j <= d + 1; j++) begin
      step();
      // R3 / R5 rising pin delayed by d, complement falls at once; R2 pair 1 undelayed
      check($sformatf("R3 R5 rise d=%0d j=%0d", d, j), pin_o[3:0],
            {2'b01, 1'b0, (j >= d) ? 1'b1 : 1'b0});
    end
    @(negedge clk);
    gen_i = 3'b000;
    for (int j = 0; j <= d + 1; j++) begin
      step();
      check($sformatf("R3 R5 fall d=%0d j=%0d", d, j), pin_o[3:0],
            {2'b10, (j >= d) ? 1'b1 : 1'b0, 1'b0});
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    even_oe_i = 1'b1; odd_oe_i = 1'b1; mask_en_i = '1; mask_val_i = '1;
    repeat (3) step();
    // R10 reset state
    check("R10 reset pins", pin_o, 6'b0);
    check("R10 reset oe", pin_oe_o, 6'b0);
    @(negedge clk); rst_n = 1'b1; mask_en_i = '0; mask_val_i = '0;
    settle(2);

    // R1 R2 R6 R7 R8 R10: sweep modes, generator values and override patterns
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 8; g++) begin
        for (int k = 0; k < 16; k++) begin
          mode_i = 2'(m); gen_i = 3'(g); dt_en_i = '0;
          mask_en_i = 6'(k * 5); mask_val_i = 6'(k * 11);
          brake_i = k[3]; brake_lvl_i = 6'(k * 7) ^ 6'h2A; neg_pol_i = 6'(k * 13);
          step();
          check($sformatf("R1 R2 R6 R7 R8 R10 m=%0d g=%0d k=%0d", m, g, k), pin_o,
                model(3'(g), 2'(m), mask_en_i, mask_val_i, brake_i, brake_lvl_i, neg_pol_i));
          @(negedge clk);
        end
      end
    end
    mask_en_i = '0; brake_i = 1'b0; neg_pol_i = '0;

    // R9 output enable groups
    for (int e = 0; e < 4; e++) begin
      even_oe_i = e[0]; odd_oe_i = e[1];
      step();
      check($sformatf("R9 oe e=%0d", e), pin_oe_o, {3{e[1], e[0]}});
      @(negedge clk);
    end
    even_oe_i = 1'b1; odd_oe_i = 1'b1;

    // R3 R5 dead-time lengths including full range
    dt_run(0); dt_run(1); dt_run(3); dt_run(7); dt_run(2047);

    // R3 restart: change inside the window
    dt_run(0);
    dt_len_i = 11'd4; dt_en_i = 3'b001; gen_i = 3'b000; settle(6);
    gen_i = 3'b001; step(); step();
    check("R3 mid-window both low", pin_o[1:0], 2'b00);
    @(negedge clk); gen_i = 3'b000;
    for (int j = 0; j <= 5; j++) begin
      step();
      check($sformatf("R3 restart j=%0d", j), pin_o[1:0], {(j >= 4) ? 1'b1 : 1'b0, 1'b0});
    end
    @(negedge clk);

    // R6 mask applies inside dead-time window
    settle(6);
    gen_i = 3'b001; mask_en_i = 6'b000001; mask_val_i = 6'b000001;
    step();
    check("R6 mask inside window", pin_o[1:0], 2'b01);
    @(negedge clk); mask_en_i = '0; mask_val_i = '0;
    step();
    check("R3 window still open after unmask", pin_o[1:0], 2'b00);
    @(negedge clk); settle(6);

    // R4 dead-time enable ignored outside complementary mode
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      mode_i = 2'(m); dt_en_i = 3'b111; dt_len_i = 11'd5; gen_i = 3'b000;
      settle(3);
      gen_i = 3'b101;
      step();
      check($sformatf("R4 no delay m=%0d", m), pin_o,
            model(3'b101, 2'(m), '0, '0, 1'b0, '0, '0));
      @(negedge clk);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule